// File: doc/BRIEF.md
# Split Two-Stage Decade Counter

This block is a four-bit decade counter made of two sections that take separate count inputs: a single toggle stage that produces output bit 0, and a modulo-five stage that produces output bits 3 to 1. A static strap input chooses how the two sections are chained. In the binary-coded mode, the external count enters the toggle stage, and each time bit 0 falls it advances the modulo-five stage. In the bi-quinary mode, the external count enters the modulo-five stage, and each time that stage wraps from 4 to 0 it toggles bit 0. Bit 0 then acts as the divide-by-ten output.

Both count inputs are asynchronous waveforms. Each one is synchronized onto the system clock, and only its high-to-low transitions are counted. The internal carry between the two stages takes effect in the same system-clock cycle as the edge that causes it, so the chain adds no latency. An active-high clear input forces all four outputs low at once, and it holds them low for as long as it is asserted. The clear is released in step with the clock. The strap is assumed to stay fixed while the counter is running.

Top module: `dcnt_decade`

## Requirements
- R1: Only a high-to-low transition of a count input advances the counter. A low-to-high transition leaves the outputs unchanged.
- R2: While `clr` is high, `q_o` is 4'b0000. The outputs go low without waiting for a clock edge, and they stay low whatever the count inputs do.
- R3: Each counted event at the toggle stage inverts `q_o[0]`.
- R4: The modulo-five stage (`q_o[3:1]`, with bit 1 least significant) steps through 0,1,2,3,4 and then returns to 0. It never holds a value above 4.
- R5: With `chain_biq`=0 (binary-coded mode), each falling edge of `cnt_tog_i` advances `q_o`, read as an unsigned number, by one through 0..9. After 9 it wraps to 0.
- R6: With `chain_biq`=1 (bi-quinary mode), each falling edge of `cnt_qui_i` advances the count c through 0..9 and then wraps to 0. The outputs read `q_o[3:1]` = c mod 5 and `q_o[0]` = 1 when c is 5 or more. So c=4 gives 4'b1000, c=5 gives 4'b0001 and c=9 gives 4'b1001.
- R7: The count input of the downstream stage has no effect. In binary-coded mode that is `cnt_qui_i`; in bi-quinary mode it is `cnt_tog_i`.
- R8: A falling edge is not counted if it is detected while the clear is in effect, or in the first cycle after the counter leaves the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock that samples the count inputs |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr | input | 1 | Asynchronous active-high counter clear |
| chain_biq | input | 1 | Static strap: 0 selects binary-coded chaining, 1 selects bi-quinary chaining |
| cnt_tog_i | input | 1 | Count input of the toggle stage (falling edge counts) |
| cnt_qui_i | input | 1 | Count input of the modulo-five stage (falling edge counts) |
| q_o | output | 4 | Counter outputs; bit 0 comes from the toggle stage, bits 3..1 from the modulo-five stage |

## Verification
Several properties are checked on every clock cycle: the range of the modulo-five stage, the range of the count in binary-coded mode, the all-zero output while the clear is high, and the fact that the outputs stay stable in any cycle with no counted edge on the selected input. Together these cover the rule that rising edges and the downstream input have no effect. The full code sequences, both wraps, the carry between the stages in each chaining mode, and the loss of edges that arrive during a clear can only be shown by the bench's directed scenarios. Those scenarios compare the outputs with a count that the bench keeps for itself.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic {
    CHAIN_BCD = 1'b0,
    CHAIN_BIQ = 1'b1
  } chain_e;

  localparam int unsigned QUI_MOD = 5;
  localparam int unsigned QUI_W   = $clog2(QUI_MOD);
  localparam int unsigned OUT_W   = QUI_W + 1;
endpackage

// File: rtl/dcnt_fall_detect.sv
module dcnt_fall_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/dcnt_reset_sync.sv
module dcnt_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic rst_out_n
);
  logic              arst_n;
  logic [STAGES-1:0] hold_q, hold_d;

  assign arst_n = rst_n & ~clr;

  always_comb hold_d = {hold_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  assign rst_out_n = hold_q[STAGES-1];
endmodule

// File: rtl/dcnt_toggle.sv
module dcnt_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic q_o
);
  logic bit_q, bit_d;

  always_comb bit_d = en ? ~bit_q : bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assign q_o = bit_q;
endmodule

// File: rtl/dcnt_quinary.sv
module dcnt_quinary #(
  parameter int unsigned MOD = 5,
  localparam int unsigned W  = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (en) val_d = (val_q == TOP) ? '0 : val_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/dcnt_decade.sv
module dcnt_decade
  import dcnt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             chain_biq,
  input  logic             cnt_tog_i,
  input  logic             cnt_qui_i,
  output logic [OUT_W-1:0] q_o
);
  localparam logic [QUI_W-1:0] QUI_TOP = QUI_W'(QUI_MOD - 1);

  chain_e           chain;
  logic             cnt_rst_n;
  logic             fall_tog, fall_qui;
  logic             run_q, run_d;
  logic             ext_tog, ext_qui;
  logic             en_tog, en_qui;
  logic             tog_q;
  logic [QUI_W-1:0] qui_q;

  assign chain = chain_e'(chain_biq);

  dcnt_reset_sync #(.STAGES(RST_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rst_out_n(cnt_rst_n)
  );

  dcnt_fall_detect #(.STAGES(SYNC_STAGES)) u_fd_tog (
    .clk(clk), .rst_n(rst_n), .din(cnt_tog_i), .fall_o(fall_tog)
  );

  dcnt_fall_detect #(.STAGES(SYNC_STAGES)) u_fd_qui (
    .clk(clk), .rst_n(rst_n), .din(cnt_qui_i), .fall_o(fall_qui)
  );

  // Blocks edges in the first cycle after the clear is released.
  always_comb run_d = 1'b1;

  always_ff @(posedge clk or negedge cnt_rst_n) begin
    if (!cnt_rst_n) run_q <= 1'b0;
    else            run_q <= run_d;
  end

  always_comb begin
    ext_tog = fall_tog & run_q;
    ext_qui = fall_qui & run_q;
    if (chain == CHAIN_BIQ) begin
      en_qui = ext_qui;
      en_tog = ext_qui & (qui_q == QUI_TOP);
    end else begin
      en_tog = ext_tog;
      en_qui = ext_tog & tog_q;
    end
  end

  dcnt_toggle u_tog (
    .clk(clk), .rst_n(cnt_rst_n), .en(en_tog), .q_o(tog_q)
  );

  dcnt_quinary #(.MOD(QUI_MOD)) u_qui (
    .clk(clk), .rst_n(cnt_rst_n), .en(en_qui), .val_o(qui_q)
  );

  assign q_o = {qui_q, tog_q};
endmodule

// File: rtl/dcnt_decade_chk.sv
module dcnt_decade_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       chain_biq,
  input logic       ext_tog,
  input logic       ext_qui,
  input logic       run_q,
  input logic       cnt_rst_n,
  input logic [3:0] q_o
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |-> (q_o == 4'b0000)); // R2
  AST_QUI_RANGE: assert property (@(posedge clk) disable iff (!rst_n) q_o[3:1] <= 3'd4); // R4
  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n) !chain_biq |-> (q_o <= 4'd9)); // R5
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n || clr) (!chain_biq && ext_tog) |=> (q_o[0] != $past(q_o[0]))); // R3
  AST_BCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr) (!chain_biq && !ext_tog) |=> $stable(q_o)); // R7
  AST_BIQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr) (chain_biq && !ext_qui) |=> $stable(q_o)); // R1
  AST_RELEASE_MASK: assert property (@(posedge clk) disable iff (!rst_n || clr) (cnt_rst_n && !run_q) |=> (q_o == 4'b0000)); // R8
endmodule

bind dcnt_decade dcnt_decade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .chain_biq(chain_biq),
  .ext_tog(ext_tog), .ext_qui(ext_qui), .run_q(run_q),
  .cnt_rst_n(cnt_rst_n), .q_o(q_o)
);

// File: tb/dcnt_decade_tb.sv
`timescale 1ns/1ps
module dcnt_decade_tb;
  logic       clk = 1'b0;
  logic       rst_n, clr, chain_biq, cnt_tog_i, cnt_qui_i;
  logic [3:0] q_o;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  dcnt_decade u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .chain_biq(chain_biq),
    .cnt_tog_i(cnt_tog_i), .cnt_qui_i(cnt_qui_i), .q_o(q_o)
  );

  function automatic logic [3:0] exp_code(input int c, input logic biq);
    int k = c % 10;
    if (!biq) return 4'(k);
    return {3'(k % 5), (k >= 5) ? 1'b1 : 1'b0};
  endfunction

  task automatic check(input logic [3:0] exp, input string req);
    n_cmp++;
    if (q_o !== exp) begin
      n_bad++;
      $display("FAIL %s: q_o=%b expected=%b", req, q_o, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit on_tog);
    if (on_tog) cnt_tog_i = 1'b1; else cnt_qui_i = 1'b1;
    wait_clk(4);
    if (on_tog) cnt_tog_i = 1'b0; else cnt_qui_i = 1'b0;
    wait_clk(4);
  endtask

  task automatic do_clear(input logic biq);
    @(negedge clk);
    chain_biq = biq;
    clr = 1'b1;
    wait_clk(2);
    clr = 1'b0;
    wait_clk(5);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; clr = 1'b0; chain_biq = 1'b0;
    cnt_tog_i = 1'b0; cnt_qui_i = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);
    check(4'b0000, "R2 reset state");
  endtask

  task automatic t_bcd_seq;
    do_clear(1'b0);
    for (int i = 1; i <= 21; i++) begin
      pulse(1'b1);
      check(exp_code(i, 1'b0), (i % 10 == 0) ? "R5 wrap" : "R5/R3 bcd step");
    end
  endtask

  task automatic t_rise_only;
    do_clear(1'b0);
    pulse(1'b1);
    cnt_tog_i = 1'b1;
    wait_clk(6);
    check(exp_code(1, 1'b0), "R1 rising edge ignored");
    cnt_tog_i = 1'b0;
    wait_clk(5);
    check(exp_code(2, 1'b0), "R1 falling edge counted");
  endtask

  task automatic t_bcd_ignore;
    do_clear(1'b0);
    pulse(1'b1);
    for (int i = 0; i < 3; i++) pulse(1'b0);
    check(exp_code(1, 1'b0), "R7 five-stage input ignored in bcd");
  endtask

  task automatic t_biq_seq;
    do_clear(1'b1);
    for (int i = 1; i <= 20; i++) begin
      pulse(1'b0);
      check(exp_code(i, 1'b1), (i % 5 == 0) ? "R6/R4 five-stage wrap" : "R6 biq step");
    end
  endtask

  task automatic t_biq_ignore;
    do_clear(1'b1);
    for (int i = 0; i < 3; i++) pulse(1'b0);
    pulse(1'b1);
    pulse(1'b1);
    check(exp_code(3, 1'b1), "R7 toggle input ignored in biq");
  endtask

  task automatic t_clear_mid;
    do_clear(1'b0);
    for (int i = 0; i < 7; i++) pulse(1'b1);
    check(exp_code(7, 1'b0), "R5 before clear");
    @(negedge clk);
    #1 clr = 1'b1;
    #0.5;
    check(4'b0000, "R2 asynchronous clear");
    cnt_tog_i = 1'b1;
    wait_clk(4);
    cnt_tog_i = 1'b0;
    wait_clk(4);
    check(4'b0000, "R2 clear overrides count");
    clr = 1'b0;
    wait_clk(6);
    check(4'b0000, "R8 edge during clear dropped");
    pulse(1'b1);
    check(exp_code(1, 1'b0), "R8 counting resumes");
  endtask

  initial begin
    t_reset();
    t_bcd_seq();
    t_rise_only();
    t_bcd_ignore();
    t_biq_seq();
    t_biq_ignore();
    t_clear_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: expected=done actual=timeout");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule